// File: doc/BRIEF.md
# CEC Frame Sender

This block puts one frame onto a single-wire, open-drain CEC bus. A caller holds a message buffer of up to sixteen bytes, a byte count and a quiet-time setting in bit periods, then pulses a start request. The block waits until the wire has been idle long enough. It sends a start bit, then ten bit slots per byte. It pulls the wire down through `drive_low_o` and watches the resolved wire level on `line_i`. All bus timing is counted in ticks of a 1 µs enable, so one counter set serves any system clock.

A logical 1 is sent by releasing the wire early and then looking at it at a fixed point after the falling edge. That one sample handles three things. In the first four bits it catches a competing initiator. In the acknowledge slot it reads the acknowledge, with the sense inverted for broadcast frames. At the end of a sampled bit it catches another node holding the wire low to flag an error. The outcome is one two-bit status code carried by a single-cycle valid pulse.

Top module: `cecbus_sender`

## Requirements
- R1: After reset `drive_low_o`, `busy_o` and `status_valid_o` are 0, and `drive_low_o` is never 1 while `busy_o` is 0.
- R2: With the wire high throughout, the first falling edge is driven on the (N·T_BIT_TOTAL+1)-th consecutive high tick after go, where N is `free_bits_i`.
- R3: A low level on the wire during the quiet-time wait clears the count, and the full N·T_BIT_TOTAL+1 high ticks are needed again after the wire returns high.
- R4: The start bit holds the wire low for T_START_LOW ticks, and the next falling edge follows T_START_TOTAL ticks after its falling edge.
- R5: Each byte (byte i sits at `msg_i[8i+7:8i]`) is sent as ten slots with a period of T_BIT_TOTAL ticks: eight data bits MSB first, an end-of-message bit that is 1 only in byte `len_i-1`, and an acknowledge slot that is always sent as 1. A 0 is low for T_BIT0_LOW ticks and a 1 is low for T_BIT1_LOW ticks.
- R6: When the block sends a 1 in one of the first four bits and the wire reads low T_SAMPLE_AT ticks after the falling edge, it stops at once. It reports status 2 (arbitration lost) with `lost_bit_o` equal to that bit index (0 to 3), and drives no further edges.
- R7: In a directed frame (low nibble of byte 0 not 15), a high acknowledge sample is a NACK. At the end of that slot the block reports status 1 and sends none of the remaining bytes.
- R8: In a broadcast frame (low nibble of byte 0 equal to 15), a low acknowledge sample is a NACK (status 1) and a high one is an acknowledge.
- R9: If the wire is low at the end of a sampled bit, the block releases it, waits for the wire to go high, and reports status 3 (low drive) on the cycle after the wire is first seen high.
- R10: When the acknowledge slot of byte `len_i-1` is acknowledged and ends with the wire high, the block reports status 0 (OK).
- R11: `busy_o` rises on the cycle after go and stays high until `status_valid_o` pulses for one cycle, with `busy_o` low in that cycle. A go while busy is ignored.
- R12: Timing advances only on cycles with `tick_i` high. With a tick every k cycles, every pulse and period lasts k times its tick count in clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 µs timing enable |
| go_i | input | 1 | Start request pulse, taken only when idle |
| msg_i | input | 8·MAX_BYTES | Message buffer, byte i at bits 8i+7:8i, held while busy |
| len_i | input | LEN_W | Byte count, 1 to MAX_BYTES, held while busy |
| free_bits_i | input | FREE_W | Required quiet time in bit periods, held while busy |
| line_i | input | 1 | Resolved wire level |
| drive_low_o | output | 1 | Pull the wire low |
| busy_o | output | 1 | Frame in progress |
| status_valid_o | output | 1 | One-cycle result strobe |
| status_o | output | 2 | 0 OK, 1 NACK, 2 arbitration lost, 3 low drive |
| lost_bit_o | output | 2 | Bit index at which arbitration was lost |

## Verification
The embedded properties check the following on every cycle:
- the wire is released whenever the block is idle or waiting out a low-drive error;
- the result strobe is a single cycle that closes a busy period;
- a start edge is only driven from a high wire;
- the bit counter stays inside one bit period;
- arbitration loss can only come from byte 0.

Only the directed scenarios can show the following, because each needs a responder that pulls the wire at chosen slots:
- the exact pulse widths and periods of the encoded frame;
- the quiet-time count and its restart;
- the acknowledge sense for directed and broadcast frames;
- the slot at which a NACK, arbitration loss or low drive cuts the frame short;
- the scaling of all timing with a sparser tick.

// File: rtl/cecbus_pkg.sv
package cecbus_pkg;

  typedef enum logic [1:0] {
    TX_OK     = 2'd0,
    TX_NACK   = 2'd1,
    TX_ARB    = 2'd2,
    TX_LOWDRV = 2'd3
  } tx_status_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_WAIT  = 3'd1,
    S_START = 3'd2,
    S_BIT   = 3'd3,
    S_HOLD  = 3'd4
  } tx_state_e;

  localparam logic [3:0] SLOT_EOM   = 4'd8;
  localparam logic [3:0] SLOT_ACK   = 4'd9;
  localparam logic [3:0] ARB_SLOTS  = 4'd4;
  localparam logic [3:0] BCAST_ADDR = 4'hF;

endpackage

// File: rtl/cecbus_free_timer.sv
module cecbus_free_timer #(
  parameter int unsigned T_BIT_TOTAL = 2400,
  parameter int unsigned FREE_W      = 4,
  localparam int unsigned CNT_W      = $clog2(((1 << FREE_W) - 1) * T_BIT_TOTAL + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic [FREE_W-1:0] free_bits_i,
  output logic              ok_o
);

  localparam logic [CNT_W-1:0] BT = CNT_W'(T_BIT_TOTAL);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thresh;

  assign thresh = CNT_W'(free_bits_i) * BT;
  assign ok_o   = arm_i & tick_i & line_i & (cnt_q >= thresh);

  // counts consecutive high ticks; any low tick restarts the wait
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!arm_i)             cnt_q <= '0;
    else if (tick_i) begin
      if (!line_i)               cnt_q <= '0;
      else if (cnt_q < thresh)   cnt_q <= cnt_q + 1'b1;
    end
  end

  p_low_restarts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && tick_i && !line_i) |=> (cnt_q == '0));

endmodule

// File: rtl/cecbus_bit_timer.sv
module cecbus_bit_timer #(
  parameter int unsigned T_START_LOW   = 3700,
  parameter int unsigned T_START_TOTAL = 4500,
  parameter int unsigned T_BIT0_LOW    = 1500,
  parameter int unsigned T_BIT1_LOW    = 600,
  parameter int unsigned T_BIT_TOTAL   = 2400,
  parameter int unsigned T_SAMPLE_AT   = 850,
  localparam int unsigned TW           = $clog2(T_START_TOTAL + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic start_ph_i,
  input  logic one_i,
  output logic rel_o,
  output logic smp_o,
  output logic end_o
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_nx;
  logic [TW-1:0] low_len;
  logic [TW-1:0] total;
  logic          step;

  assign step    = run_i & tick_i;
  assign cnt_nx  = cnt_q + 1'b1;
  assign low_len = start_ph_i ? TW'(T_START_LOW)
                 : (one_i ? TW'(T_BIT1_LOW) : TW'(T_BIT0_LOW));
  assign total   = start_ph_i ? TW'(T_START_TOTAL) : TW'(T_BIT_TOTAL);

  assign rel_o = step & (cnt_nx == low_len);
  assign smp_o = step & ~start_ph_i & (cnt_nx == TW'(T_SAMPLE_AT));
  assign end_o = step & (cnt_nx == total);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step)   cnt_q <= cnt_nx;
  end

  p_cnt_in_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_ph_i) |-> (cnt_q < TW'(T_BIT_TOTAL)));

  p_cnt_in_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && start_ph_i) |-> (cnt_q < TW'(T_START_TOTAL)));

endmodule

// File: rtl/cecbus_slot_sel.sv
module cecbus_slot_sel
  import cecbus_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 16,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int unsigned IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic [MAX_BYTES*8-1:0] msg_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [IDX_W-1:0]       byte_i,
  input  logic [3:0]             slot_i,
  output logic                   bit_o,
  output logic                   sampled_o,
  output logic                   last_o,
  output logic                   ack_slot_o,
  output logic                   bcast_o
);

  logic [7:0] bytes [MAX_BYTES];
  logic [7:0] cur;
  logic       last_byte;

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_unpack
    assign bytes[i] = msg_i[i*8 +: 8];
  end

  assign cur        = bytes[byte_i];
  assign last_byte  = (LEN_W'(byte_i) + LEN_W'(1)) == len_i;
  assign ack_slot_o = (slot_i == SLOT_ACK);
  assign bcast_o    = (bytes[0][3:0] == BCAST_ADDR);
  assign last_o     = last_byte & ack_slot_o;

  always_comb begin
    if (slot_i < SLOT_EOM)        bit_o = cur[3'd7 - slot_i[2:0]];
    else if (slot_i == SLOT_EOM)  bit_o = last_byte;
    else                          bit_o = 1'b1;
  end

  // a released 1 is checked in the arbitration field and in every ack slot
  assign sampled_o = bit_o & (ack_slot_o | ((byte_i == '0) & (slot_i < ARB_SLOTS)));

endmodule

// File: rtl/cecbus_sender.sv
module cecbus_sender
  import cecbus_pkg::*;
#(
  parameter int unsigned MAX_BYTES     = 16,
  parameter int unsigned FREE_W        = 4,
  parameter int unsigned T_START_LOW   = 3700,
  parameter int unsigned T_START_TOTAL = 4500,
  parameter int unsigned T_BIT0_LOW    = 1500,
  parameter int unsigned T_BIT1_LOW    = 600,
  parameter int unsigned T_BIT_TOTAL   = 2400,
  parameter int unsigned T_SAMPLE_AT   = 850,
  localparam int unsigned LEN_W        = $clog2(MAX_BYTES + 1),
  localparam int unsigned IDX_W        = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   go_i,
  input  logic [MAX_BYTES*8-1:0] msg_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [FREE_W-1:0]      free_bits_i,
  input  logic                   line_i,
  output logic                   drive_low_o,
  output logic                   busy_o,
  output logic                   status_valid_o,
  output logic [1:0]             status_o,
  output logic [1:0]             lost_bit_o
);

  tx_state_e        state_q;
  tx_status_e       stat_q;
  logic [IDX_W-1:0] byte_q;
  logic [3:0]       slot_q;
  logic             drive_q;
  logic             nack_q;
  logic             stat_vld_q;
  logic [1:0]       pos_q;

  logic free_ok;
  logic t_rel, t_smp, t_end;
  logic cur_bit, sampled, last, ack_slot, bcast;
  logic low_at_end, nack_end, next_bit, timer_clr, arb_hit;

  cecbus_free_timer #(
    .T_BIT_TOTAL (T_BIT_TOTAL),
    .FREE_W      (FREE_W)
  ) u_free (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (state_q == S_WAIT),
    .tick_i      (tick_i),
    .line_i      (line_i),
    .free_bits_i (free_bits_i),
    .ok_o        (free_ok)
  );

  cecbus_slot_sel #(
    .MAX_BYTES (MAX_BYTES)
  ) u_sel (
    .msg_i      (msg_i),
    .len_i      (len_i),
    .byte_i     (byte_q),
    .slot_i     (slot_q),
    .bit_o      (cur_bit),
    .sampled_o  (sampled),
    .last_o     (last),
    .ack_slot_o (ack_slot),
    .bcast_o    (bcast)
  );

  cecbus_bit_timer #(
    .T_START_LOW   (T_START_LOW),
    .T_START_TOTAL (T_START_TOTAL),
    .T_BIT0_LOW    (T_BIT0_LOW),
    .T_BIT1_LOW    (T_BIT1_LOW),
    .T_BIT_TOTAL   (T_BIT_TOTAL),
    .T_SAMPLE_AT   (T_SAMPLE_AT)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (timer_clr),
    .run_i      ((state_q == S_START) || (state_q == S_BIT)),
    .tick_i     (tick_i),
    .start_ph_i (state_q == S_START),
    .one_i      (cur_bit),
    .rel_o      (t_rel),
    .smp_o      (t_smp),
    .end_o      (t_end)
  );

  assign arb_hit    = (state_q == S_BIT) & t_smp & sampled & ~line_i & ~ack_slot;
  assign low_at_end = sampled & ~line_i;
  assign nack_end   = sampled & nack_q;
  assign next_bit   = (state_q == S_BIT) & t_end & ~low_at_end & ~nack_end & ~last;
  assign timer_clr  = ((state_q == S_WAIT) & free_ok)
                    | ((state_q == S_START) & t_end)
                    | next_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      stat_q     <= TX_OK;
      byte_q     <= '0;
      slot_q     <= '0;
      drive_q    <= 1'b0;
      nack_q     <= 1'b0;
      stat_vld_q <= 1'b0;
      pos_q      <= '0;
    end else begin
      stat_vld_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (go_i) begin
          state_q <= S_WAIT;
          nack_q  <= 1'b0;
        end
        S_WAIT: if (free_ok) begin
          state_q <= S_START;
          drive_q <= 1'b1;
        end
        S_START: begin
          if (t_end) begin
            state_q <= S_BIT;
            byte_q  <= '0;
            slot_q  <= '0;
            drive_q <= 1'b1;
          end else if (t_rel) begin
            drive_q <= 1'b0;
          end
        end
        S_BIT: begin
          if (arb_hit) begin
            state_q    <= S_IDLE;
            stat_q     <= TX_ARB;
            stat_vld_q <= 1'b1;
            pos_q      <= slot_q[1:0];
            drive_q    <= 1'b0;
          end else begin
            // directed: low = acked; broadcast: low = rejected
            if (t_smp && sampled && ack_slot) nack_q <= bcast ? ~line_i : line_i;
            if (t_end) begin
              if (low_at_end) begin
                state_q <= S_HOLD;
                drive_q <= 1'b0;
              end else if (nack_end || last) begin
                state_q    <= S_IDLE;
                stat_q     <= nack_end ? TX_NACK : TX_OK;
                stat_vld_q <= 1'b1;
                drive_q    <= 1'b0;
              end else begin
                drive_q <= 1'b1;
                if (slot_q == SLOT_ACK) begin
                  slot_q <= '0;
                  byte_q <= byte_q + 1'b1;
                end else begin
                  slot_q <= slot_q + 1'b1;
                end
              end
            end else if (t_rel) begin
              drive_q <= 1'b0;
            end
          end
        end
        S_HOLD: if (line_i) begin
          state_q    <= S_IDLE;
          stat_q     <= TX_LOWDRV;
          stat_vld_q <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign drive_low_o    = drive_q;
  assign busy_o         = (state_q != S_IDLE);
  assign status_valid_o = stat_vld_q;
  assign status_o       = stat_q;
  assign lost_bit_o     = pos_q;

  p_released_when_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !drive_low_o);

  p_status_closes_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_valid_o |-> (!busy_o && $past(busy_o)));

  p_single_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_valid_o |=> !status_valid_o);

  p_start_from_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(drive_low_o) && ($past(state_q) == S_WAIT)) |-> $past(line_i));

  p_hold_released_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HOLD) |-> !drive_low_o);

  p_arb_in_first_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_valid_o && (status_o == 2'd2)) |-> ($past(byte_q) == '0));

endmodule

// File: tb/cecbus_sender_bench.sv
module cecbus_sender_bench;

  localparam int DS  = 74;
  localparam int DT  = 90;
  localparam int D0  = 30;
  localparam int D1  = 12;
  localparam int DB  = 48;
  localparam int DSA = 17;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick;
  logic         go = 1'b0;
  logic [127:0] msg = '0;
  logic [4:0]   len = 5'd1;
  logic [3:0]   free_bits = '0;
  logic         line;
  logic         drive_low, busy, st_vld;
  logic [1:0]   st_code_w, lost_w;
  logic         man_low = 1'b0;
  logic         pull_active = 1'b0;

  always #4 clk = ~clk;

  assign line = !(drive_low | man_low | pull_active);

  cecbus_sender #(
    .T_START_LOW(DS), .T_START_TOTAL(DT), .T_BIT0_LOW(D0),
    .T_BIT1_LOW(D1), .T_BIT_TOTAL(DB), .T_SAMPLE_AT(DSA)
  ) u_cecbus_sender (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .go_i(go), .msg_i(msg),
    .len_i(len), .free_bits_i(free_bits), .line_i(line),
    .drive_low_o(drive_low), .busy_o(busy), .status_valid_o(st_vld),
    .status_o(st_code_w), .lost_bit_o(lost_w)
  );

  int cyc = 0;
  int div = 1;
  int tdiv = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    tdiv <= (tdiv + 1 >= div) ? 0 : tdiv + 1;
  end
  assign tick = (tdiv == 0);

  // monitor and responder
  int fall [0:1023];
  int rise [0:1023];
  int nf = 0, nr = 0;
  int pull [0:63];
  int pull_base = 0;
  int pull_left = 0;
  logic dl_prev = 1'b0;
  int st_n = 0, st_code = 0, st_pos = 0, st_cyc = 0;

  always @(negedge clk) begin
    if (drive_low && !dl_prev) begin
      fall[nf] = cyc;
      if (nf - pull_base < 64 && pull[nf - pull_base] > 0)
        pull_left = pull[nf - pull_base];
      nf = nf + 1;
    end else if (pull_left > 0) begin
      pull_left = pull_left - 1;
    end
    if (!drive_low && dl_prev) begin
      rise[nr] = cyc;
      nr = nr + 1;
    end
    dl_prev = drive_low;
    pull_active = (pull_left > 0);
    if (st_vld) begin
      st_n    = st_n + 1;
      st_code = st_code_w;
      st_pos  = lost_w;
      st_cyc  = cyc;
    end
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int go_cyc = 0;
  int base = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_bit(input int g);
    int s, b, k;
    s = g - 1; b = s / 10; k = s % 10;
    if (k < 8) return int'(msg[b*8 + 7 - k]);
    if (k == 8) return (b == int'(len) - 1) ? 1 : 0;
    return 1;
  endfunction

  task automatic launch(input logic [127:0] m, input int l, input int fb, input int d);
    @(negedge clk);
    msg = m; len = 5'(l); free_bits = 4'(fb); div = d;
    for (int i = 0; i < 64; i++) pull[i] = 0;
    base = nf;
    pull_base = nf;
  endtask

  task automatic fire();
    @(negedge clk);
    go = 1'b1; go_cyc = cyc;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_status(input string tag);
    int n0;
    n0 = st_n;
    for (int i = 0; i < 20000 && st_n == n0; i++) @(negedge clk);
    chk(st_n != n0, tag, st_n, n0 + 1);
  endtask

  task automatic check_frame(input int n_exp, input int d);
    int bad_act, bad_exp, errs, lo, pe;
    chk(nf - base == n_exp, "R5 edge count", nf - base, n_exp);
    if (nf - base != n_exp || nr - base < n_exp) return;
    chk(rise[base] - fall[base] == DS * d, "R4 start low",
        rise[base] - fall[base], DS * d);
    if (n_exp > 1)
      chk(fall[base+1] - fall[base] == DT * d, "R4 start period",
          fall[base+1] - fall[base], DT * d);
    errs = 0; bad_act = 0; bad_exp = 0;
    for (int g = 1; g < n_exp; g++) begin
      lo = rise[base+g] - fall[base+g];
      if (lo != (exp_bit(g) ? D1 : D0) * d) begin
        if (errs == 0) begin bad_act = lo; bad_exp = (exp_bit(g) ? D1 : D0) * d; end
        errs++;
      end
      if (g < n_exp - 1) begin
        pe = fall[base+g+1] - fall[base+g];
        if (pe != DB * d) begin
          if (errs == 0) begin bad_act = pe; bad_exp = DB * d; end
          errs++;
        end
      end
    end
    chk(errs == 0, "R5 bit widths/periods", bad_act, bad_exp);
  endtask

  task automatic sc_reset();
    chk(drive_low == 1'b0, "R1 drive_low after reset", int'(drive_low), 0);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(st_vld == 1'b0, "R1 status_valid after reset", int'(st_vld), 0);
  endtask

  task automatic sc_directed_ok();
    int n_hold;
    launch({112'h0, 8'hC3, 8'h4A}, 2, 1, 1);
    pull[10] = D0; pull[20] = D0;
    fire();
    repeat (300) @(negedge clk);
    chk(busy == 1'b1, "R11 busy mid-frame", int'(busy), 1);
    go = 1'b1; @(negedge clk); go = 1'b0;   // ignored while busy
    wait_status("R10 status arrives");
    chk(st_code == 0, "R10 status OK", st_code, 0);
    chk(fall[base] - go_cyc == DB + 2, "R2 quiet-time start", fall[base] - go_cyc, DB + 2);
    check_frame(21, 1);
    chk(busy == 1'b0, "R11 busy low after strobe", int'(busy), 0);
    n_hold = nf;
    repeat (300) @(negedge clk);
    chk(nf == n_hold && !busy, "R11 go while busy ignored", nf - n_hold, 0);
  endtask

  task automatic sc_defer_bcast();
    int r;
    launch({120'h0, 8'h1F}, 1, 1, 1);
    fire();
    repeat (5) @(negedge clk);
    man_low = 1'b1;
    repeat (10) @(negedge clk);
    man_low = 1'b0; r = cyc;
    wait_status("R3 status arrives");
    chk(fall[base] - r == DB + 1, "R3 wait restarts after low", fall[base] - r, DB + 1);
    chk(st_code == 0, "R8 broadcast high ack is OK", st_code, 0);
    check_frame(11, 1);
  endtask

  task automatic sc_bcast_nack();
    launch({112'h0, 8'h12, 8'h3F}, 2, 0, 1);
    pull[10] = D0;
    fire();
    wait_status("R8 status arrives");
    chk(st_code == 1, "R8 broadcast low ack is NACK", st_code, 1);
    repeat (200) @(negedge clk);
    chk(nf - base == 11, "R8 stops after NACK byte", nf - base, 11);
  endtask

  task automatic sc_directed_nack();
    launch({104'h0, 8'h22, 8'h11, 8'h04}, 3, 0, 1);
    pull[10] = D0;
    fire();
    wait_status("R7 status arrives");
    chk(st_code == 1, "R7 directed NACK", st_code, 1);
    repeat (500) @(negedge clk);
    check_frame(21, 1);
    chk(drive_low == 1'b0, "R7 wire released", int'(drive_low), 0);
  endtask

  task automatic sc_arb();
    launch({112'h0, 8'h55, 8'h70}, 2, 0, 1);
    pull[3] = D0;
    fire();
    wait_status("R6 status arrives");
    chk(st_code == 2, "R6 arbitration lost code", st_code, 2);
    chk(st_pos == 2, "R6 lost bit index", st_pos, 2);
    repeat (300) @(negedge clk);
    chk(nf - base == 4, "R6 no edges after loss", nf - base, 4);
    chk(drive_low == 1'b0, "R6 wire released", int'(drive_low), 0);
  endtask

  task automatic sc_lowdrive();
    launch({120'h0, 8'h05}, 1, 0, 1);
    pull[10] = 72;
    fire();
    wait_status("R9 status arrives");
    chk(st_code == 3, "R9 low drive code", st_code, 3);
    chk(st_cyc - fall[base+10] == 73, "R9 reported once wire high",
        st_cyc - fall[base+10], 73);
    check_frame(11, 1);
  endtask

  task automatic sc_tick_div();
    launch({120'h0, 8'h81}, 1, 0, 3);
    pull[10] = D0 * 3;
    fire();
    wait_status("R12 status arrives");
    chk(st_code == 0, "R12 OK with sparse tick", st_code, 0);
    check_frame(11, 3);
    chk(fall[base+10] - fall[base] == (DT + 9 * DB) * 3, "R12 scaled frame span",
        fall[base+10] - fall[base], (DT + 9 * DB) * 3);
    div = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    sc_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sc_reset();
    sc_directed_ok();
    sc_defer_bcast();
    sc_bcast_nack();
    sc_directed_nack();
    sc_arb();
    sc_lowdrive();
    sc_tick_div();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule